// File: doc/BRIEF.md
# Page-Based Slot Select Decoder

This block maps a 64 KB processor memory space onto four primary expansion slots. The space is cut into four 16 KB pages. An 8-bit mapping register holds one 2-bit slot number per page. On each memory access the two highest address bits pick a page, the page's slot number is read out of the register, and one of four active-low slot-select lines is driven low for the length of the access.

The same access also produces the cartridge window strobes, which are one strobe for each of the two middle pages and one for both together. It produces the enable pair for the built-in ROM, which sits in slot 0 and answers only in the lower 32 KB, and a control that isolates the external cartridge data buffer. Software writes and reads back the mapping register through an I/O port. Refresh cycles and idle bus cycles drive no select.

Top module: `slot_page_decoder`

## Requirements
- R1: After reset the mapping register reads 0x00, so every page resolves to slot 0.
- R2: A write strobe stores the write data in the mapping register at the clock edge. The read port shows the new value from then on.
- R3: The page is the top two address bits (0 = 0x0000–0x3FFF through 3 = 0xC000–0xFFFF). The page's slot is read from register bits [2p+1:2p], so page 0 uses [1:0], page 1 uses [3:2], page 2 uses [5:4] and page 3 uses [7:6].
- R4: An access is active when the memory request is high and refresh is low. During an active access exactly one slot-select line is low, at the index of the selected slot (bit n = slot n).
- R5: When the memory request is low or refresh is high, every slot select, window strobe and ROM enable is high.
- R6: The first window strobe is low only during an active access to page 1. The second window strobe is low only during an active access to page 2.
- R7: The combined window strobe is low exactly when either window strobe is low.
- R8: The ROM chip select equals slot-select line 0. The ROM output enable is low only when that chip select is low and address bit 15 is 0.
- R9: The buffer-isolate output is low only during an active access to a slot other than 0 with no I/O cycle in progress. Otherwise it is high.
- R10: An access in the same cycle as a register write is decoded with the old register value. The new value applies after the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Write strobe of the mapping register port |
| cfg_wdata | input | 8 | Write data for the mapping register |
| cfg_rdata | output | 8 | Current mapping register value |
| mem_req | input | 1 | Memory request, active high |
| rfsh | input | 1 | Refresh cycle, active high |
| io_cyc | input | 1 | I/O cycle in progress, active high |
| addr_top | input | 2 | Address bits 15 and 14 |
| slot_sel_n | output | 4 | Slot selects, active low, bit n = slot n |
| win1_n | output | 1 | Strobe for window 0x4000–0x7FFF, active low |
| win2_n | output | 1 | Strobe for window 0x8000–0xBFFF, active low |
| win12_n | output | 1 | Strobe for 0x4000–0xBFFF, active low |
| rom_cs_n | output | 1 | Built-in ROM chip select, active low |
| rom_oe_n | output | 1 | Built-in ROM output enable, active low |
| ext_buf_iso | output | 1 | High isolates the cartridge data buffer |

## Verification
The mapping register is the only state. A corrupted or misrouted field shows at once on the slot-select lines during the first active access to the affected page, in the same cycle. It shows on the read port one edge after the write. Each of several register patterns is therefore swept over all four pages, so that each 2-bit field is seen to steer its own page and no other. A write that lands during an access is checked on both sides of the clock edge, which exposes any bypass of the register.

// File: rtl/slotdec_pkg.sv
package slotdec_pkg;
  parameter int SLOT_W    = 2;
  parameter int PAGE_BITS = 2;
  parameter int NPAGES    = 1 << PAGE_BITS;
  parameter int NSLOTS    = 1 << SLOT_W;
  parameter int MAP_W     = NPAGES * SLOT_W;

  typedef logic [SLOT_W-1:0]    slot_t;
  typedef logic [PAGE_BITS-1:0] page_t;
  typedef logic [MAP_W-1:0]     map_t;

  // Slot number that the map assigns to a page.
  function automatic slot_t map_field(input map_t m, input page_t pg);
    return m[pg*SLOT_W +: SLOT_W];
  endfunction

  // Active-low one-hot line pattern for a slot.
  function automatic logic [NSLOTS-1:0] slot_lines_n(input logic en, input slot_t s);
    logic [NSLOTS-1:0] v;
    v = '1;
    if (en) v[s] = 1'b0;
    return v;
  endfunction
endpackage

// File: rtl/slot_map_reg.sv
module slot_map_reg
  import slotdec_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  map_t wdata,
  output map_t map_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) map_q <= '0;
    else if (wr_en) map_q <= wdata;
  end

  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> map_q == $past(wdata));
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(map_q));
endmodule

// File: rtl/slot_page_sel.sv
module slot_page_sel
  import slotdec_pkg::*;
(
  input  map_t  map_q,
  input  page_t page,
  output slot_t slot
);
  always_comb slot = map_field(map_q, page);
endmodule

// File: rtl/slot_line_dec.sv
module slot_line_dec
  import slotdec_pkg::*;
(
  input  logic              en,
  input  slot_t             slot,
  output logic [NSLOTS-1:0] sel_n
);
  for (genvar i = 0; i < NSLOTS; i++) begin : g_line
    assign sel_n[i] = !(en && (slot == slot_t'(i)));
  end
endmodule

// File: rtl/slot_window_dec.sv
module slot_window_dec
  import slotdec_pkg::*;
#(
  parameter int LO_PAGE = 1,
  parameter int HI_PAGE = 2
) (
  input  logic  en,
  input  page_t page,
  output logic  lo_n,
  output logic  hi_n,
  output logic  both_n
);
  logic lo_hit, hi_hit;
  assign lo_hit = en && (page == page_t'(LO_PAGE));
  assign hi_hit = en && (page == page_t'(HI_PAGE));
  assign lo_n   = !lo_hit;
  assign hi_n   = !hi_hit;
  assign both_n = !(en && (page >= page_t'(LO_PAGE)) && (page <= page_t'(HI_PAGE)));
endmodule

// File: rtl/slot_page_decoder.sv
module slot_page_decoder
  import slotdec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [MAP_W-1:0]  cfg_wdata,
  output logic [MAP_W-1:0]  cfg_rdata,
  input  logic              mem_req,
  input  logic              rfsh,
  input  logic              io_cyc,
  input  logic [PAGE_BITS-1:0] addr_top,
  output logic [NSLOTS-1:0] slot_sel_n,
  output logic              win1_n,
  output logic              win2_n,
  output logic              win12_n,
  output logic              rom_cs_n,
  output logic              rom_oe_n,
  output logic              ext_buf_iso
);
  localparam int WIN_LO = 1;
  localparam int WIN_HI = 2;

  map_t  map_q;
  slot_t cur_slot;
  logic  access_act;
  logic  upper_half;

  assign access_act = mem_req && !rfsh;
  assign upper_half = addr_top[PAGE_BITS-1];

  slot_map_reg u_map (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .wdata(cfg_wdata), .map_q(map_q)
  );

  slot_page_sel u_sel (
    .map_q(map_q), .page(addr_top), .slot(cur_slot)
  );

  slot_line_dec u_lines (
    .en(access_act), .slot(cur_slot), .sel_n(slot_sel_n)
  );

  slot_window_dec #(.LO_PAGE(WIN_LO), .HI_PAGE(WIN_HI)) u_win (
    .en(access_act), .page(addr_top),
    .lo_n(win1_n), .hi_n(win2_n), .both_n(win12_n)
  );

  assign cfg_rdata   = map_q;
  assign rom_cs_n    = slot_sel_n[0];
  assign rom_oe_n    = rom_cs_n || upper_half;
  assign ext_buf_iso = io_cyc || (&slot_sel_n[NSLOTS-1:1]);

  a_r4_one_line: assert property (@(posedge clk) disable iff (!rst_n)
    access_act |-> ($countones(~slot_sel_n) == 1 && slot_sel_n == slot_lines_n(1'b1, map_field(map_q, addr_top))));
  a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !access_act |-> (&slot_sel_n && win1_n && win2_n && win12_n && rom_oe_n));
  a_r7_combined: assert property (@(posedge clk) disable iff (!rst_n)
    win12_n == (win1_n && win2_n));
  a_r6_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
    !(win1_n == 1'b0 && win2_n == 1'b0));
  a_r8_rom_oe: assert property (@(posedge clk) disable iff (!rst_n)
    !rom_oe_n |-> (!slot_sel_n[0] && !upper_half));
  a_r9_io_isolates: assert property (@(posedge clk) disable iff (!rst_n)
    io_cyc |-> ext_buf_iso);
endmodule

// File: tb/slot_page_decoder_tb.sv
module slot_page_decoder_tb;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       cfg_wr = 0;
  logic [7:0] cfg_wdata = 0;
  logic [7:0] cfg_rdata;
  logic       mem_req = 0, rfsh = 0, io_cyc = 0;
  logic [1:0] addr_top = 0;
  logic [3:0] slot_sel_n;
  logic       win1_n, win2_n, win12_n, rom_cs_n, rom_oe_n, ext_buf_iso;
  int total = 0;
  int bad = 0;
  logic [7:0] shadow;

  always #5 clk = ~clk;

  slot_page_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .mem_req(mem_req), .rfsh(rfsh), .io_cyc(io_cyc),
    .addr_top(addr_top), .slot_sel_n(slot_sel_n), .win1_n(win1_n),
    .win2_n(win2_n), .win12_n(win12_n), .rom_cs_n(rom_cs_n),
    .rom_oe_n(rom_oe_n), .ext_buf_iso(ext_buf_iso)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected outputs computed from the requirement text.
  task automatic check_access(input logic [7:0] m, input logic [1:0] pg,
                              input logic req, input logic rf, input logic io);
    logic act;
    logic [1:0] s;
    logic [3:0] lines;
    logic w1, w2;
    act = req && !rf;
    s = (m >> (2 * pg)) & 8'h3;
    lines = act ? ~(4'b0001 << s) : 4'b1111;
    w1 = !(act && pg == 2'd1);
    w2 = !(act && pg == 2'd2);
    mem_req = req; rfsh = rf; io_cyc = io; addr_top = pg;
    #1;
    chk("R3/R4 slot lines", {4'h0, slot_sel_n}, {4'h0, lines});
    chk("R6 win1", {7'h0, win1_n}, {7'h0, w1});
    chk("R6 win2", {7'h0, win2_n}, {7'h0, w2});
    chk("R7 win12", {7'h0, win12_n}, {7'h0, w1 && w2});
    chk("R8 rom_cs", {7'h0, rom_cs_n}, {7'h0, lines[0]});
    chk("R8 rom_oe", {7'h0, rom_oe_n}, {7'h0, !(!lines[0] && !pg[1])});
    chk("R9 buf iso", {7'h0, ext_buf_iso}, {7'h0, !(act && s != 2'd0 && !io)});
  endtask

  task automatic write_map(input logic [7:0] v);
    @(negedge clk);
    cfg_wr = 1; cfg_wdata = v;
    @(negedge clk);
    cfg_wr = 0;
    shadow = v;
    #1 chk("R2 readback", cfg_rdata, v);
  endtask

  task automatic test_reset;
    @(negedge clk);
    chk("R1 reset value", cfg_rdata, 8'h00);
    for (int p = 0; p < 4; p++) check_access(8'h00, p[1:0], 1'b1, 1'b0, 1'b0);
  endtask

  task automatic test_pattern(input logic [7:0] v);
    write_map(v);
    for (int p = 0; p < 4; p++) begin
      @(negedge clk);
      check_access(shadow, p[1:0], 1'b1, 1'b0, 1'b0);
    end
  endtask

  task automatic test_idle_refresh;
    write_map(8'hE4);
    for (int p = 0; p < 4; p++) begin
      @(negedge clk);
      check_access(shadow, p[1:0], 1'b0, 1'b0, 1'b0);  // R5 no request
      check_access(shadow, p[1:0], 1'b1, 1'b1, 1'b0);  // R5 refresh
    end
  endtask

  task automatic test_io_cycle;
    write_map(8'hFF);
    for (int p = 0; p < 4; p++) begin
      @(negedge clk);
      check_access(shadow, p[1:0], 1'b1, 1'b0, 1'b1);  // R9 io cycle isolates
    end
  endtask

  task automatic test_same_cycle_write;
    write_map(8'h00);
    @(negedge clk);
    cfg_wr = 1; cfg_wdata = 8'hAA;
    check_access(8'h00, 2'd2, 1'b1, 1'b0, 1'b0);   // R10 old value before edge
    @(negedge clk);
    cfg_wr = 0; shadow = 8'hAA;
    check_access(8'hAA, 2'd2, 1'b1, 1'b0, 1'b0);   // R10 new value after edge
    chk("R10 readback", cfg_rdata, 8'hAA);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    shadow = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    test_reset();
    test_pattern(8'hE4);
    test_pattern(8'h1B);
    test_pattern(8'hFF);
    test_pattern(8'h93);
    test_pattern(8'h00);
    test_idle_refresh();
    test_io_cycle();
    test_same_cycle_write();
    mem_req = 0;
    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule